// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front-End

This block is the software-facing side of a serial port. It sits between a simple word-wide register bus and a separate frame engine that handles bit timing on the line. Four 32-bit registers are decoded on word offsets: control (0x0), receive data (0x4), transmit data (0x8) and status (0xC). Bytes written by software go into a transmit FIFO. The FIFO drains towards the frame engine over a valid/ready stream. Bytes from the engine, each with an error flag, arrive on a second stream and are queued in a receive FIFO until software reads them.

The control register holds the line format settings: word length, stop bits, parity, flow control and loopback. It also holds the global enable, the two DMA enables and the two interrupt enables. These settings are driven straight out to the engine. The status register mixes read-only FIFO and line flags with five sticky event bits that are cleared by writing 1. A single level-high interrupt is raised from the two pending flags.

Stream rules. On the transmit side, `tx_valid` rises only while the port is enabled and the FIFO holds data. `tx_data` then holds the oldest byte and stays stable until a cycle with `tx_ready` high pops it. Clearing the enable withdraws `tx_valid`. The receive side never applies back-pressure while enabled: `rx_ready` equals the enable bit. A byte offered while the receive FIFO is full is dropped and recorded as an overrun.

Top module: `uart_regfront`

## Requirements
- R1: During and right after reset, control reads 0, the irq output is low, and status reads 0x420 (receive-empty bit 5 and transmit-empty bit 10 set, every other bit 0).
- R2: Control accepts writes only to bits [2:0], [6:4], 12 and [20:14] (mask 0x001FD077), and other bits read 0. Bits [1:0] word length, bit 2 two-stop, [6:4] parity, bit 12 flow, bit 15 enable, bit 16 RX DMA, bit 17 TX DMA and bit 20 loopback drive the matching config outputs.
- R3: A write to offset 0x8 pushes bits [7:0] into the transmit FIFO. While enabled, the bytes leave on the tx stream in write order, and `tx_data` is held while `tx_ready` is low.
- R4: A write to offset 0x8 while the transmit FIFO is full (status bit 6) is dropped and sets status bit 3. Writing 1 to bit 3 clears it.
- R5: A read of offset 0x4 returns the oldest received byte in bits [7:0] and pops it. A read with the FIFO empty returns 0 and changes nothing.
- R6: A byte offered on the rx stream while enabled and with the receive FIFO full is discarded and sets status bit 2. Writing 1 to bit 2 clears it.
- R7: Status bit 4 shows the error flag of the byte at the head of the receive FIFO. Writing 1 to bit 4 hides it until that byte is popped. The bit reads 0 when the FIFO is empty.
- R8: Status bit 0 (RX pending) is set while the receive FIFO is non-empty. Status bit 1 (TX pending) is set while the transmit level is at most half the depth. Writing 1 clears a pending bit, which reads 0 for one cycle and is set again on the next cycle if its condition still holds.
- R9: The irq output is high exactly when (bit 0 and control bit 18) or (bit 1 and control bit 19).
- R10: Status bits [16:11] give the transmit FIFO level when control bit 14 is 1, and the receive FIFO level when it is 0.
- R11: Status bit 6 shows transmit full, bit 5 receive empty and bit 10 transmit empty. Bits 7, 8 and 17 mirror the `line_cts`, `line_rts` and `engine_busy` inputs.
- R12: With control bit 15 clear, `tx_valid` and `rx_ready` are low, and rx stream bytes are not stored. Transmit writes still queue and are sent once the port is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| tx_valid | output | 1 | Transmit byte available to the engine |
| tx_ready | input | 1 | Engine takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Block accepts received bytes |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Error flag for the received byte |
| line_cts | input | 1 | Clear-to-send state from the line |
| line_rts | input | 1 | Request-to-send state from the engine |
| engine_busy | input | 1 | Engine is shifting a frame |
| cfg_word_len | output | 2 | Word length code |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_parity | output | 3 | Parity mode code |
| cfg_flow | output | 1 | Hardware flow control on |
| cfg_loopback | output | 1 | Internal loopback |
| cfg_enable | output | 1 | Port enabled |
| dma_rx_en | output | 1 | Receive DMA enable |
| dma_tx_en | output | 1 | Transmit DMA enable |
| irq | output | 1 | Level-high interrupt |

## Verification
A wrong FIFO count appears on the level field and on the full and empty bits. These are read combinationally, so the error shows in the very cycle it occurs. A stuck pointer shows up as the wrong byte order at the next pop, on either `tx_data` or the receive read. A faulty sticky or pending register shows one cycle after the causing event or the clearing write. It shows both on the status word and on `irq`, and the one-cycle re-arm gap of the pending bits makes an error in the set/clear priority directly visible. A lost head error flag appears on bit 4 as soon as that byte reaches the head.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  // register select, from bus_addr[3:2]
  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_RXD  = 2'd1,
    RG_TXD  = 2'd2,
    RG_STAT = 2'd3
  } reg_sel_e;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned LVL_W  = 6;

  // control bit positions
  localparam int unsigned CB_WLEN   = 0;
  localparam int unsigned CB_STOP   = 2;
  localparam int unsigned CB_PAR    = 4;
  localparam int unsigned CB_FLOW   = 12;
  localparam int unsigned CB_LVLTX  = 14;
  localparam int unsigned CB_EN     = 15;
  localparam int unsigned CB_RXDMA  = 16;
  localparam int unsigned CB_TXDMA  = 17;
  localparam int unsigned CB_RXIE   = 18;
  localparam int unsigned CB_TXIE   = 19;
  localparam int unsigned CB_LOOP   = 20;
  localparam logic [31:0] CTRL_MASK = 32'h001F_D077;

  // status bit positions
  localparam int unsigned SB_RXP   = 0;
  localparam int unsigned SB_TXP   = 1;
  localparam int unsigned SB_OVR   = 2;
  localparam int unsigned SB_TXERR = 3;
  localparam int unsigned SB_RXERR = 4;
  localparam int unsigned SB_RXE   = 5;
  localparam int unsigned SB_TXF   = 6;
  localparam int unsigned SB_CTS   = 7;
  localparam int unsigned SB_RTS   = 8;
  localparam int unsigned SB_TXE   = 10;
  localparam int unsigned SB_LVL   = 11;
  localparam int unsigned SB_BUSY  = 17;
  localparam int unsigned N_W1C    = 5;

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  // pointer wrap: free for power-of-two depths, compared otherwise
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_any
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_nxt;
      if (do_pop)  rd_ptr <= rd_nxt;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_rf_events.sv
module uart_rf_events (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] clr,
  input  logic       rx_cond,
  input  logic       tx_cond,
  input  logic       ovr_set,
  input  logic       txerr_set,
  input  logic       head_err,
  input  logic       rx_empty,
  input  logic       rx_pop,
  input  logic       rx_ie,
  input  logic       tx_ie,
  output logic       rx_pend,
  output logic       tx_pend,
  output logic       ovr,
  output logic       txerr,
  output logic       rxerr,
  output logic       irq
);

  logic [1:0] pend_q, pend_cond;
  logic [1:0] err_q, err_set;
  logic       err_ack_q;

  assign pend_cond = {tx_cond, rx_cond};
  assign err_set   = {txerr_set, ovr_set};

  // pending flags: a clear write wins for one cycle, then the condition re-arms
  for (genvar i = 0; i < 2; i++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[i] <= 1'b0;
      else if (clr[i]) pend_q[i] <= 1'b0;
      else             pend_q[i] <= pend_q[i] | pend_cond[i];
    end
  end

  // error stickies: a new event in the clearing cycle still lands
  for (genvar i = 0; i < 2; i++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q[i] <= 1'b0;
      else        err_q[i] <= (err_q[i] & ~clr[2 + i]) | err_set[i];
    end
  end

  // head error acknowledge: held until the head byte leaves
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_ack_q <= 1'b0;
    else if (rx_pop) err_ack_q <= 1'b0;
    else if (clr[4]) err_ack_q <= 1'b1;
  end

  assign rx_pend = pend_q[0];
  assign tx_pend = pend_q[1];
  assign ovr     = err_q[0];
  assign txerr   = err_q[1];
  assign rxerr   = head_err && !rx_empty && !err_ack_q;
  assign irq     = (pend_q[0] && rx_ie) || (pend_q[1] && tx_ie);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_err,
  input  logic        line_cts,
  input  logic        line_rts,
  input  logic        engine_busy,
  output logic [1:0]  cfg_word_len,
  output logic        cfg_two_stop,
  output logic [2:0]  cfg_parity,
  output logic        cfg_flow,
  output logic        cfg_loopback,
  output logic        cfg_enable,
  output logic        dma_rx_en,
  output logic        dma_tx_en,
  output logic        irq
);

  localparam int unsigned TX_CW = $clog2(TX_DEPTH + 1);
  localparam int unsigned RX_CW = $clog2(RX_DEPTH + 1);
  localparam int unsigned TX_HALF = TX_DEPTH / 2;

  logic [31:0]       ctrl_q;
  reg_sel_e          sel;
  logic              wr_stb, rd_stb;
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic [TX_CW-1:0]  tx_cnt;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [RX_CW-1:0]  rx_cnt;
  logic [DATA_W:0]   rx_head;
  logic              st_rxp, st_txp, st_ovr, st_txerr, st_rxerr;
  logic [N_W1C-1:0]  w1c;
  logic [LVL_W-1:0]  lvl;
  logic [31:0]       stat;
  logic              unused_addr;

  assign unused_addr = ^bus_addr[1:0];
  assign sel    = reg_sel_e'(bus_addr[3:2]);
  assign wr_stb = bus_en && bus_we;
  assign rd_stb = bus_en && !bus_we;

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ctrl_q <= '0;
    else if (wr_stb && sel == RG_CTRL) ctrl_q <= bus_wdata & CTRL_MASK;
  end

  assign cfg_word_len = ctrl_q[CB_WLEN +: 2];
  assign cfg_two_stop = ctrl_q[CB_STOP];
  assign cfg_parity   = ctrl_q[CB_PAR +: 3];
  assign cfg_flow     = ctrl_q[CB_FLOW];
  assign cfg_enable   = ctrl_q[CB_EN];
  assign dma_rx_en    = ctrl_q[CB_RXDMA];
  assign dma_tx_en    = ctrl_q[CB_TXDMA];
  assign cfg_loopback = ctrl_q[CB_LOOP];

  // transmit path
  assign tx_push  = wr_stb && sel == RG_TXD;
  assign tx_valid = cfg_enable && !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;

  uart_rf_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_push),
    .wdata (bus_wdata[DATA_W-1:0]),
    .pop   (tx_pop),
    .rdata (tx_data),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (tx_empty)
  );

  // receive path: never back-pressures while enabled
  assign rx_ready = cfg_enable;
  assign rx_push  = rx_valid && rx_ready;
  assign rx_pop   = rd_stb && sel == RG_RXD && !rx_empty;

  uart_rf_fifo #(.WIDTH(DATA_W + 1), .DEPTH(RX_DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .wdata ({rx_err, rx_data}),
    .pop   (rx_pop),
    .rdata (rx_head),
    .count (rx_cnt),
    .full  (rx_full),
    .empty (rx_empty)
  );

  // sticky events and interrupt
  assign w1c = (wr_stb && sel == RG_STAT) ? bus_wdata[N_W1C-1:0] : '0;

  uart_rf_events u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (w1c),
    .rx_cond   (!rx_empty),
    .tx_cond   (tx_cnt <= TX_CW'(TX_HALF)),
    .ovr_set   (rx_push && rx_full),
    .txerr_set (tx_push && tx_full),
    .head_err  (rx_head[DATA_W]),
    .rx_empty  (rx_empty),
    .rx_pop    (rx_pop),
    .rx_ie     (ctrl_q[CB_RXIE]),
    .tx_ie     (ctrl_q[CB_TXIE]),
    .rx_pend   (st_rxp),
    .tx_pend   (st_txp),
    .ovr       (st_ovr),
    .txerr     (st_txerr),
    .rxerr     (st_rxerr),
    .irq       (irq)
  );

  // status word
  assign lvl = ctrl_q[CB_LVLTX] ? LVL_W'(tx_cnt) : LVL_W'(rx_cnt);

  always_comb begin
    stat               = '0;
    stat[SB_RXP]       = st_rxp;
    stat[SB_TXP]       = st_txp;
    stat[SB_OVR]       = st_ovr;
    stat[SB_TXERR]     = st_txerr;
    stat[SB_RXERR]     = st_rxerr;
    stat[SB_RXE]       = rx_empty;
    stat[SB_TXF]       = tx_full;
    stat[SB_CTS]       = line_cts;
    stat[SB_RTS]       = line_rts;
    stat[SB_TXE]       = tx_empty;
    stat[SB_LVL +: LVL_W] = lvl;
    stat[SB_BUSY]      = engine_busy;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_stb) begin
      case (sel)
        RG_CTRL: bus_rdata = ctrl_q;
        RG_RXD:  bus_rdata = rx_empty ? '0 : {24'd0, rx_head[DATA_W-1:0]};
        RG_STAT: bus_rdata = stat;
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16,
  localparam int unsigned TX_CW = $clog2(TX_DEPTH + 1),
  localparam int unsigned RX_CW = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             cfg_enable,
  input logic             irq,
  input logic             tx_full,
  input logic             rx_full,
  input logic             rx_empty,
  input logic [TX_CW-1:0] tx_cnt,
  input logic [RX_CW-1:0] rx_cnt,
  input logic             st_rxp,
  input logic             st_txp,
  input logic             st_ovr,
  input logic             st_txerr,
  input logic             st_rxerr
);

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!cfg_enable || (tx_valid && $stable(tx_data))));

  assert_tx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TX_CW'(TX_DEPTH));

  assert_tx_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr[3:2] == 2'd2 && tx_full) |=> st_txerr);

  assert_rx_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr[3:2] == 2'd1 && !rx_empty && !(rx_valid && rx_ready))
      |=> (rx_cnt == $past(rx_cnt) - 1'b1));

  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_full) |=> st_ovr);

  assert_rxerr_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !st_rxerr);

  assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr[3:2] == 2'd3 && bus_wdata[0]) |=> !st_rxp);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_rxp || st_txp));

  assert_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> (!tx_valid && !rx_ready));

endmodule

bind uart_regfront uart_regfront_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .cfg_enable (cfg_enable),
  .irq        (irq),
  .tx_full    (tx_full),
  .rx_full    (rx_full),
  .rx_empty   (rx_empty),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt),
  .st_rxp     (st_rxp),
  .st_txp     (st_txp),
  .st_ovr     (st_ovr),
  .st_txerr   (st_txerr),
  .st_rxerr   (st_rxerr)
);

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;

  localparam int unsigned TXD = 16;
  localparam int unsigned RXD = 16;
  localparam logic [3:0] A_CTRL = 4'h0, A_RXD = 4'h4, A_TXD = 4'h8, A_STAT = 4'hC;
  localparam logic [31:0] EN = 32'h0000_8000;

  // {write value, expected read-back}
  localparam logic [63:0] CTRL_VEC [6] = '{
    {32'hFFFF_FFFF, 32'h001F_D077},
    {32'h0000_8003, 32'h0000_8003},
    {32'h0004_0071, 32'h0004_0071},
    {32'h0010_5004, 32'h0010_5004},
    {32'h0002_2008, 32'h0002_0000},
    {32'hFFE0_2888, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        line_cts = 1'b0, line_rts = 1'b0, engine_busy = 1'b0;
  logic [1:0]  cfg_word_len;
  logic        cfg_two_stop, cfg_flow, cfg_loopback, cfg_enable, dma_rx_en, dma_tx_en, irq;
  logic [2:0]  cfg_parity;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  uart_regfront #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (
    .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .tx_valid, .tx_ready, .tx_data, .rx_valid, .rx_ready, .rx_data, .rx_err,
    .line_cts, .line_rts, .engine_busy, .cfg_word_len, .cfg_two_stop,
    .cfg_parity, .cfg_flow, .cfg_loopback, .cfg_enable, .dma_rx_en,
    .dma_tx_en, .irq
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic e);
    rx_valid = 1'b1; rx_data = b; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  task automatic tx_take(input logic [7:0] exp, input string tag);
    #1;
    check(tag, {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, exp});
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    // R1: reset state, observed while reset is held
    repeat (3) @(negedge clk);
    bus_rd(A_CTRL, r);  check("R1 ctrl", r, 32'h0);
    bus_rd(A_STAT, r);  check("R1 stat", r, 32'h0000_0420);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_rd(A_STAT, r);  check("R8 tx pending after reset", r, 32'h0000_0422);

    // R2: control mask table
    for (int i = 0; i < 6; i++) begin
      bus_wr(A_CTRL, CTRL_VEC[i][63:32]);
      bus_rd(A_CTRL, r);
      check("R2 ctrl readback", r, CTRL_VEC[i][31:0]);
      check("R2 cfg outputs",
        {19'd0, cfg_loopback, dma_tx_en, dma_rx_en, cfg_enable, cfg_flow, cfg_parity, cfg_two_stop, cfg_word_len},
        {19'd0, CTRL_VEC[i][20], CTRL_VEC[i][17], CTRL_VEC[i][16], CTRL_VEC[i][15], CTRL_VEC[i][12],
         CTRL_VEC[i][6:4], CTRL_VEC[i][2], CTRL_VEC[i][1:0]});
    end

    // R3/R10: ordered transmit, tx level selected
    bus_wr(A_CTRL, EN | 32'h4000);
    bus_wr(A_TXD, 32'hFFFF_FFA1);
    bus_wr(A_TXD, 32'h0000_00B2);
    bus_wr(A_TXD, 32'h0000_00C3);
    bus_rd(A_STAT, r);  check("R10 tx level", (r >> 11) & 32'h3F, 32'd3);
    @(negedge clk);
    #1 check("R3 data held while stalled", {24'd0, tx_data}, 32'hA1);
    tx_take(8'hA1, "R3 byte0");
    tx_take(8'hB2, "R3 byte1");
    tx_take(8'hC3, "R3 byte2");
    bus_rd(A_STAT, r);  check("R11 tx empty bit10", (r >> 10) & 1, 32'd1);

    // R8: clear tx pending, zero for one cycle then re-armed
    bus_wr(A_STAT, 32'h2);
    bus_rd(A_STAT, r);  check("R8 tx pend cleared", (r >> 1) & 1, 32'd0);
    bus_rd(A_STAT, r);  check("R8 tx pend rearmed", (r >> 1) & 1, 32'd1);

    // R9: interrupt follows enables
    bus_wr(A_CTRL, EN | 32'h8_0000);
    #1 check("R9 irq tx", {31'd0, irq}, 32'd1);
    bus_wr(A_CTRL, EN | 32'h4000);
    #1 check("R9 irq off", {31'd0, irq}, 32'd0);

    // R4: fill, overflow write dropped
    for (int i = 0; i < TXD; i++) bus_wr(A_TXD, 32'(i));
    bus_wr(A_STAT, 32'h2);
    bus_rd(A_STAT, r);
    check("R11 tx full bit6", (r >> 6) & 1, 32'd1);
    check("R8 tx pend stays clear above half", (r >> 1) & 1, 32'd0);
    bus_wr(A_TXD, 32'h0000_00EE);
    bus_rd(A_STAT, r);
    check("R4 tx error set", (r >> 3) & 1, 32'd1);
    check("R4 level unchanged", (r >> 11) & 32'h3F, 32'd16);
    bus_wr(A_STAT, 32'h8);
    bus_rd(A_STAT, r);  check("R4 tx error cleared", (r >> 3) & 1, 32'd0);
    #1 check("R3 head after fill", {24'd0, tx_data}, 32'h00);
    tx_ready = 1'b1;
    repeat (TXD - 1) @(negedge clk);
    #1 check("R4 last byte not the dropped one", {24'd0, tx_data}, 32'h0F);
    @(negedge clk);
    tx_ready = 1'b0;
    bus_rd(A_STAT, r);  check("R4 drained", (r >> 10) & 1, 32'd1);

    // R5/R7/R8/R9/R10: receive path
    bus_wr(A_CTRL, EN | 32'h4_0000);
    bus_wr(A_STAT, 32'h1);
    rx_send(8'h5A, 1'b0);
    rx_send(8'h66, 1'b1);
    @(negedge clk);
    bus_rd(A_STAT, r);
    check("R8 rx pending", r & 1, 32'd1);
    check("R10 rx level", (r >> 11) & 32'h3F, 32'd2);
    check("R7 head clean", (r >> 4) & 1, 32'd0);
    check("R11 rx not empty", (r >> 5) & 1, 32'd0);
    #1 check("R9 irq rx", {31'd0, irq}, 32'd1);
    bus_rd(A_RXD, r);   check("R5 first byte", r, 32'h5A);
    bus_rd(A_STAT, r);  check("R7 head error shown", (r >> 4) & 1, 32'd1);
    bus_wr(A_STAT, 32'h10);
    bus_rd(A_STAT, r);  check("R7 head error hidden", (r >> 4) & 1, 32'd0);
    bus_rd(A_RXD, r);   check("R5 second byte", r, 32'h66);
    bus_rd(A_RXD, r);   check("R5 empty read", r, 32'h0);
    bus_rd(A_STAT, r);  check("R5 level zero after empty read", (r >> 11) & 32'h3F, 32'd0);
    bus_wr(A_STAT, 32'h1);
    @(negedge clk);
    bus_rd(A_STAT, r);  check("R8 rx pend stays clear when empty", r & 1, 32'd0);
    #1 check("R9 irq rx off", {31'd0, irq}, 32'd0);

    // R6: overrun
    for (int i = 0; i <= RXD; i++) rx_send(8'(i), 1'b0);
    bus_rd(A_STAT, r);
    check("R6 overrun set", (r >> 2) & 1, 32'd1);
    check("R6 level full", (r >> 11) & 32'h3F, 32'd16);
    bus_wr(A_STAT, 32'h4);
    bus_rd(A_STAT, r);  check("R6 overrun cleared", (r >> 2) & 1, 32'd0);
    bus_rd(A_RXD, r);   check("R6 oldest kept", r, 32'h00);
    for (int i = 1; i < RXD - 1; i++) bus_rd(A_RXD, r);
    bus_rd(A_RXD, r);   check("R6 newest kept is 15", r, 32'h0F);

    // R12: disabled port
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_TXD, 32'h77);
    #1 check("R12 tx_valid low", {30'd0, tx_valid, rx_ready}, 32'd0);
    rx_send(8'h11, 1'b0);
    bus_rd(A_STAT, r);  check("R12 rx not stored", (r >> 5) & 1, 32'd1);
    bus_wr(A_CTRL, EN);
    tx_take(8'h77, "R12 queued byte sent after enable");

    // R11: line state mirrors
    line_cts = 1'b1; line_rts = 1'b1; engine_busy = 1'b1;
    bus_rd(A_STAT, r);
    check("R11 line bits", r & 32'h0002_0180, 32'h0002_0180);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule